// File: doc/BRIEF.md
# Predicated Execution Gate with Status Flags

This block sits beside the execute stage and decides, for each instruction word, whether it may change any state. It holds the four status flags (negative, zero, carry, overflow) in a register. It tests them against a 4-bit predicate in the top bits of the instruction. The result is an execute-enable that the surrounding pipeline uses to gate the register-file write.

When the predicate fails, the instruction acts as a no-operation. It writes no register and leaves the flags untouched. A passing instruction loads the flags only when its flag-set bit is 1 and the ALU raises its flag-update request. A flag value written by one instruction is seen by the predicate of the next instruction.

The predicate code 1111 is never executed. The block flags it on a separate output so that the pipeline can trap on it. The predicate evaluator comes in two equivalent forms, chosen by a parameter: a full decoder or a factored pairwise evaluator.

Top module: `cx_pred_unit`

## Requirements
- R1: A synchronous active-high reset clears all four flags to 0, and reset takes priority over any update in the same cycle. The flags output packs them as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.
- R2: While `instr_valid` is low, `exec_en` and `cond_unsup` are 0 and the flags do not change.
- R3: Predicate codes (instruction bits 31:28) 0000 to 0111 pass on Z=1, Z=0, C=1, C=0, N=1, N=0, V=1 and V=0, in that code order.
- R4: Code 1000 passes when C=1 and Z=0. Code 1001 passes when C=0 or Z=1.
- R5: Code 1010 passes when N equals V, and 1011 when N differs from V. Code 1100 passes when Z=0 and N equals V, and 1101 when Z=1 or N differs from V.
- R6: Code 1110 passes for every flag value.
- R7: Code 1111 never passes. While `instr_valid` is high with this code, `cond_unsup` is 1.
- R8: `exec_en` is combinational from the predicate and the registered flags. When `exec_en`, instruction bit 20 and `flag_req` are all 1, the flags take `alu_nzcv` at the next clock edge. The next instruction's predicate then sees these new flags.
- R9: An executed instruction with bit 20 at 0 leaves the flags unchanged, even when `flag_req` is 1.
- R10: An instruction whose predicate fails leaves the flags unchanged, even with bit 20 and `flag_req` both 1.
- R11: With `flag_req` low, an executed instruction with bit 20 set leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 32 | Instruction word; bits 31:28 predicate, bit 20 flag-set |
| instr_valid | input | 1 | Instruction present this cycle |
| alu_nzcv | input | 4 | Next flag values from the ALU {N,Z,C,V} |
| flag_req | input | 1 | ALU request to load the flags |
| exec_en | output | 1 | Instruction may write state |
| flags | output | 4 | Registered flags {N,Z,C,V} |
| cond_unsup | output | 1 | Valid instruction carries the never-execute code |

## Verification
`exec_en` and `cond_unsup` respond in the same cycle as the instruction. The bench therefore drives inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. A flag load appears one rising edge after the instruction that requests it. Flags are checked at the following falling edge, and the predicate of the instruction presented there is checked against the new values. Each predicate vector is preceded by an always-executing load that sets its flags one cycle ahead, so the flag timing is used in every table entry.

// File: rtl/cx_pkg.sv
package cx_pkg;

   localparam int FLAG_W = 4;
   localparam int PRED_W = 4;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

   typedef enum logic [PRED_W-1:0] {
      P_ZS = 4'h0, P_ZC = 4'h1, P_CS = 4'h2, P_CC = 4'h3,
      P_NS = 4'h4, P_NC = 4'h5, P_VS = 4'h6, P_VC = 4'h7,
      P_UHI = 4'h8, P_ULS = 4'h9, P_SGE = 4'hA, P_SLT = 4'hB,
      P_SGT = 4'hC, P_SLE = 4'hD, P_ANY = 4'hE, P_NONE = 4'hF
   } pred_e;

   localparam int EVAL_DECODE   = 0;
   localparam int EVAL_FACTORED = 1;

endpackage

// File: rtl/cx_cond_eval.sv
module cx_cond_eval
   import cx_pkg::*;
#(
   parameter int STYLE = EVAL_DECODE
)(
   input  logic [PRED_W-1:0] pred,
   input  nzcv_t             f,
   output logic              pass
);

   generate
      if (STYLE == EVAL_DECODE) begin : g_decode
         always_comb begin
            unique case (pred_e'(pred))
               P_ZS:   pass = f.z;
               P_ZC:   pass = !f.z;
               P_CS:   pass = f.c;
               P_CC:   pass = !f.c;
               P_NS:   pass = f.n;
               P_NC:   pass = !f.n;
               P_VS:   pass = f.v;
               P_VC:   pass = !f.v;
               P_UHI:  pass = f.c && !f.z;
               P_ULS:  pass = !f.c || f.z;
               P_SGE:  pass = (f.n == f.v);
               P_SLT:  pass = (f.n != f.v);
               P_SGT:  pass = !f.z && (f.n == f.v);
               P_SLE:  pass = f.z || (f.n != f.v);
               P_ANY:  pass = 1'b1;
               P_NONE: pass = 1'b0;
               default: pass = 1'b0;
            endcase
         end
      end else if (STYLE == EVAL_FACTORED) begin : g_factored
         logic base;
         always_comb begin
            unique case (pred[PRED_W-1:1])
               3'd0: base = f.z;
               3'd1: base = f.c;
               3'd2: base = f.n;
               3'd3: base = f.v;
               3'd4: base = f.c && !f.z;
               3'd5: base = (f.n == f.v);
               3'd6: base = !f.z && (f.n == f.v);
               3'd7: base = 1'b1;
               default: base = 1'b0;
            endcase
         end
         assign pass = base ^ pred[0];
      end else begin : g_bad_style
         $error("cx_cond_eval: STYLE must be EVAL_DECODE or EVAL_FACTORED");
      end
   endgenerate

endmodule

// File: rtl/cx_flag_store.sv
module cx_flag_store
   import cx_pkg::*;
#(
   parameter logic [FLAG_W-1:0] RESET_VAL = '0
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [FLAG_W-1:0] d,
   output logic [FLAG_W-1:0] q
);

   genvar gi;
   generate
      for (gi = 0; gi < FLAG_W; gi++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk) begin
            if (rst)       bit_q <= RESET_VAL[gi];
            else if (load) bit_q <= d[gi];
         end
         assign q[gi] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/cx_pred_unit.sv
module cx_pred_unit
   import cx_pkg::*;
#(
   parameter int INSTR_W    = 32,
   parameter int SET_BIT    = 20,
   parameter int EVAL_STYLE = EVAL_FACTORED
)(
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr_word,
   input  logic               instr_valid,
   input  logic [FLAG_W-1:0]  alu_nzcv,
   input  logic               flag_req,
   output logic               exec_en,
   output logic [FLAG_W-1:0]  flags,
   output logic               cond_unsup
);

   localparam int PRED_LSB = INSTR_W - PRED_W;

   generate
      if (INSTR_W < PRED_W + 1) begin : g_w_chk
         $error("cx_pred_unit: INSTR_W too small for predicate field");
      end
      if (SET_BIT < 0 || SET_BIT >= PRED_LSB) begin : g_s_chk
         $error("cx_pred_unit: SET_BIT must lie below the predicate field");
      end
   endgenerate

   logic [PRED_W-1:0] pred;
   logic              set_req;
   logic              pass;
   logic              load;

   assign pred    = instr_word[INSTR_W-1:PRED_LSB];
   assign set_req = instr_word[SET_BIT];

   cx_cond_eval #(
      .STYLE (EVAL_STYLE)
   ) u_eval (
      .pred (pred),
      .f    (nzcv_t'(flags)),
      .pass (pass)
   );

   assign exec_en    = instr_valid && pass;
   assign cond_unsup = instr_valid && (pred == P_NONE);
   assign load       = exec_en && set_req && flag_req;

   cx_flag_store #(
      .RESET_VAL ('0)
   ) u_flags (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .d    (alu_nzcv),
      .q    (flags)
   );

endmodule

// File: rtl/cx_pred_unit_chk.sv
module cx_pred_unit_chk
   import cx_pkg::*;
#(
   parameter int INSTR_W = 32,
   parameter int SET_BIT = 20
)(
   input logic               clk,
   input logic               rst,
   input logic [INSTR_W-1:0] instr_word,
   input logic               instr_valid,
   input logic [FLAG_W-1:0]  alu_nzcv,
   input logic               flag_req,
   input logic               exec_en,
   input logic [FLAG_W-1:0]  flags,
   input logic               cond_unsup
);

   logic rst_seen;
   always_ff @(posedge clk) rst_seen <= rst;

   // R1
   always @(negedge clk) begin
      if (rst_seen === 1'b1)
         reset_clear_chk: assert (flags == '0);
   end

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !instr_valid |-> (!exec_en && !cond_unsup));

   // R7
   never_code_chk: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr_word[INSTR_W-1 -: 4] == 4'hF) |-> (!exec_en && cond_unsup));

   // R6
   always_code_chk: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr_word[INSTR_W-1 -: 4] == 4'hE) |-> exec_en);

   // R8
   flag_load_chk: assert property (@(posedge clk) disable iff (rst)
      (exec_en && instr_word[SET_BIT] && flag_req) |=> (flags == $past(alu_nzcv)));

   // R9
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !(exec_en && instr_word[SET_BIT] && flag_req) |=> $stable(flags));

   // R10
   fail_no_load_chk: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && !exec_en) |=> $stable(flags));

endmodule

bind cx_pred_unit cx_pred_unit_chk #(
   .INSTR_W (INSTR_W),
   .SET_BIT (SET_BIT)
) u_chk (
   .clk         (clk),
   .rst         (rst),
   .instr_word  (instr_word),
   .instr_valid (instr_valid),
   .alu_nzcv    (alu_nzcv),
   .flag_req    (flag_req),
   .exec_en     (exec_en),
   .flags       (flags),
   .cond_unsup  (cond_unsup)
);

// File: tb/cx_pred_unit_test.sv
`timescale 1ns/1ps
module cx_pred_unit_test;

   logic        clk = 1'b0;
   logic        rst;
   logic [31:0] instr_word;
   logic        instr_valid;
   logic [3:0]  alu_nzcv;
   logic        flag_req;
   logic        exec_en;
   logic [3:0]  flags;
   logic        cond_unsup;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   cx_pred_unit uut (
      .clk         (clk),
      .rst         (rst),
      .instr_word  (instr_word),
      .instr_valid (instr_valid),
      .alu_nzcv    (alu_nzcv),
      .flag_req    (flag_req),
      .exec_en     (exec_en),
      .flags       (flags),
      .cond_unsup  (cond_unsup)
   );

   // {predicate, flags NZCV, expected exec}
   localparam int NV = 25;
   localparam logic [8:0] VEC [NV] = '{
      {4'h0, 4'b0100, 1'b1}, {4'h0, 4'b0000, 1'b0},
      {4'h1, 4'b0000, 1'b1}, {4'h1, 4'b0100, 1'b0},
      {4'h2, 4'b0010, 1'b1}, {4'h3, 4'b0010, 1'b0},
      {4'h4, 4'b1000, 1'b1}, {4'h5, 4'b1000, 1'b0},
      {4'h6, 4'b0001, 1'b1}, {4'h7, 4'b0000, 1'b1},
      {4'h8, 4'b0010, 1'b1}, {4'h8, 4'b0110, 1'b0},
      {4'h9, 4'b0110, 1'b1}, {4'h9, 4'b0010, 1'b0},
      {4'hA, 4'b1001, 1'b1}, {4'hA, 4'b1000, 1'b0},
      {4'hB, 4'b1000, 1'b1}, {4'hB, 4'b0000, 1'b0},
      {4'hC, 4'b0000, 1'b1}, {4'hC, 4'b0100, 1'b0},
      {4'hC, 4'b0001, 1'b0}, {4'hD, 4'b0001, 1'b1},
      {4'hD, 4'b0000, 1'b0}, {4'hE, 4'b1111, 1'b1},
      {4'hF, 4'b1111, 1'b0}
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] p, input logic s, input logic v,
                        input logic req, input logic [3:0] nf);
      instr_word  = {p, 7'd0, s, 20'h00ABC};
      instr_valid = v;
      flag_req    = req;
      alu_nzcv    = nf;
   endtask

   function automatic string tag_of(input logic [3:0] p);
      if (p < 4'h8)       return "R3";
      else if (p < 4'hA)  return "R4";
      else if (p < 4'hE)  return "R5";
      else if (p == 4'hE) return "R6";
      else                return "R7";
   endfunction

   initial begin
      rst = 1'b1;
      drive(4'h0, 1'b0, 1'b0, 1'b0, 4'h0);
      repeat (3) @(negedge clk);
      check("R1 reset flags", {28'd0, flags}, 32'h0);
      check("R2 reset idle exec", {31'd0, exec_en}, 32'h0);
      rst = 1'b0;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(4'hE, 1'b1, 1'b1, 1'b1, VEC[i][4:1]);
         @(negedge clk);
         drive(VEC[i][8:5], 1'b0, 1'b1, 1'b0, 4'h0);
         #1;
         check("R8 preload visible", {28'd0, flags}, {28'd0, VEC[i][4:1]});
         check(tag_of(VEC[i][8:5]), {31'd0, exec_en}, {31'd0, VEC[i][0]});
         check("R7 unsup flag", {31'd0, cond_unsup}, {31'd0, VEC[i][8:5] == 4'hF});
      end

      // R9: S clear, flags kept
      @(negedge clk); drive(4'hE, 1'b1, 1'b1, 1'b1, 4'h0);
      @(negedge clk); drive(4'hE, 1'b0, 1'b1, 1'b1, 4'hF);
      #1 check("R9 exec with S=0", {31'd0, exec_en}, 32'h1);
      @(negedge clk);
      check("R9 flags held", {28'd0, flags}, 32'h0);
      // R11: no request
      drive(4'hE, 1'b1, 1'b1, 1'b0, 4'hF);
      @(negedge clk);
      check("R11 flags held", {28'd0, flags}, 32'h0);
      // R10: failing predicate
      drive(4'h0, 1'b1, 1'b1, 1'b1, 4'hF);
      #1 check("R10 exec low", {31'd0, exec_en}, 32'h0);
      @(negedge clk);
      check("R10 flags held", {28'd0, flags}, 32'h0);
      // R2: not valid
      drive(4'hE, 1'b1, 1'b0, 1'b1, 4'hF);
      #1 check("R2 exec low", {31'd0, exec_en}, 32'h0);
      @(negedge clk);
      check("R2 flags held", {28'd0, flags}, 32'h0);
      drive(4'hF, 1'b1, 1'b0, 1'b1, 4'hF);
      #1 check("R2 unsup low", {31'd0, cond_unsup}, 32'h0);
      // R8: back-to-back visibility
      @(negedge clk); drive(4'hE, 1'b1, 1'b1, 1'b1, 4'b0100);
      @(negedge clk); drive(4'h0, 1'b1, 1'b1, 1'b1, 4'b1010);
      #1 check("R8 next sees Z", {31'd0, exec_en}, 32'h1);
      @(negedge clk); drive(4'hA, 1'b1, 1'b1, 1'b1, 4'hF);
      #1 check("R8 flags loaded", {28'd0, flags}, 32'hA);
      check("R8 GE fails on N!=V", {31'd0, exec_en}, 32'h0);
      // R7: never code
      @(negedge clk); drive(4'hF, 1'b1, 1'b1, 1'b1, 4'hF);
      #1 check("R7 exec low", {31'd0, exec_en}, 32'h0);
      check("R7 unsup high", {31'd0, cond_unsup}, 32'h1);
      @(negedge clk);
      check("R7 flags held", {28'd0, flags}, 32'hA);
      // R1: reset beats update
      rst = 1'b1;
      drive(4'hE, 1'b1, 1'b1, 1'b1, 4'hF);
      @(negedge clk);
      check("R1 reset priority", {28'd0, flags}, 32'h0);
      rst = 1'b0;
      drive(4'h0, 1'b0, 1'b0, 1'b0, 4'h0);
      @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule